// File: doc/BRIEF.md
# Reloadable Down-Counter Timer with Pulse and Event Modes

This block is an 8-bit interval timer fed by an 8-bit prescaler. Both stages count down and reload from a latch, so each divides its input by one more than the value held in its latch. The prescaler advances on a clock-enable tick that arrives already divided from the system clock tree. The timer counts either prescaler outputs or edges seen on an external input pin.

A small mode register picks between plain interval timing, a square-wave pulse output that toggles on every underflow, and event counting of rising or falling pin edges. A single edge-select bit sets both the starting level of the pulse output and the polarity of counted edges. Each underflow raises a sticky interrupt request that software clears with a strobe. Software writes the mode register, the prescaler latch and the timer latch through plain write strobes, and reads the live timer value on a dedicated output.

Top module: `rtm_timer`

## Requirements
- R1: The prescaler divides incoming ticks by P+1, where P is its latch value, in timer mode (mode field 00) and pulse mode (01). A prescaler latch write loads its counter as well while the timer is not running, and only the latch while it runs.
- R2: The timer decrements once per count pulse. A count pulse that finds the timer at 0x00 is an underflow and reloads the timer latch value, so the timer period is L+1 count pulses.
- R3: Each underflow drives irq_o to 1 on the next clock edge. irq_o stays at 1 until irq_clr is pulsed. If an underflow and irq_clr fall in the same cycle, the set wins.
- R4: The mode register is cfg_wdata[3:0], with bits [1:0] holding the mode, bit 2 the edge select and bit 3 stop. While stop is 1, neither the timer nor the prescaler changes except by a direct load.
- R5: A timer write while the timer is not running loads both the latch and count_o. While it runs, the write updates only the latch, and the new value is first used at the next reload.
- R6: In pulse mode, pulse_o inverts at every underflow. In every other mode, pulse_o holds its level.
- R7: In pulse mode, a timer write sets pulse_o on the next edge to 1 when edge select is 0 and to 0 when it is 1. This happens whether the timer is running or stopped.
- R8: A mode-register write that stays in pulse mode but changes the edge select bit inverts pulse_o on the next edge.
- R9: In event mode (10), the timer ignores ticks and counts edges of ext_pin_i. Edge select 0 counts rising edges and 1 counts falling edges. A pin change is counted on the third clock edge after it.
- R10: Mode 11 halts counting. count_o does not change, pulse_o holds and irq_o is not set.
- R11: After reset, count_o is 0xFF and both latches hold 0xFF. pulse_o is 1, irq_o is 0, and the mode register is stopped timer mode (4'b1000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Pre-divided count-source enable |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_wdata | input | 4 | Mode register data: [3] stop, [2] edge select, [1:0] mode |
| pre_we | input | 1 | Prescaler latch write strobe |
| pre_wdata | input | 8 | Prescaler latch data |
| tmr_we | input | 1 | Timer latch write strobe |
| tmr_wdata | input | 8 | Timer latch data |
| irq_clr | input | 1 | Clears the interrupt request |
| ext_pin_i | input | 1 | External counter pin, asynchronous |
| pulse_o | output | 1 | Pulse output pin level |
| irq_o | output | 1 | Sticky underflow interrupt request |
| count_o | output | 8 | Live timer count |

## Verification
Writes, ticks and underflows show up on count_o, pulse_o and irq_o one rising edge after the cycle that carries them. A pin change in event mode reaches count_o only on the third edge, because of the two-flop synchroniser and the edge detector. The bench changes inputs on the falling edge and steps its own model on the rising edge. It compares every output on the next falling edge, so each result is read exactly one edge after its cause, and each pin edge is checked on the cycle its three-edge delay ends.

// File: rtl/rtm_pkg.sv
// Shared types for the reloadable multi-mode timer.
package rtm_pkg;
    typedef enum logic [1:0] {
        MODE_TIMER = 2'b00,
        MODE_PULSE = 2'b01,
        MODE_EVENT = 2'b10,
        MODE_HALT  = 2'b11
    } rtm_mode_e;

    // Mode register layout: [3] stop, [2] edge select, [1:0] mode.
    typedef struct packed {
        logic      stop;
        logic      edge_sel;
        rtm_mode_e mode;
    } rtm_cfg_t;

    localparam int CFG_W = $bits(rtm_cfg_t);
endpackage

// File: rtl/rtm_prescaler.sv
// Reloadable down-counting prescaler. It emits one pulse every (latch+1)
// enabled ticks.
// Assumes: run_i already combines stop, mode and the source choice.
// load_i says whether a latch write also loads the counter.
module rtm_prescaler #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic             wr_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic             pulse_o
);
    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

    logic [WIDTH-1:0] latch_q;
    logic [WIDTH-1:0] cnt_q;

    assign pulse_o = run_i && tick_i && (cnt_q == '0);

    // Hold the reload value written by software.
    always_ff @(posedge clk) begin
        if (!rst_n)    latch_q <= ALL_ONES;
        else if (wr_i) latch_q <= wdata_i;
    end

    // Count down on enabled ticks and reload at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt_q <= ALL_ONES;
        else if (wr_i && load_i)   cnt_q <= wdata_i;
        else if (run_i && tick_i)  cnt_q <= (cnt_q == '0) ? latch_q : cnt_q - 1'b1;
    end
endmodule

// File: rtl/rtm_pin_edge.sv
// Synchronises the external pin through STAGES flops and flags one
// selected edge against the previous synchronised sample.
// Assumes: the pin is low during reset. fall_sel_i=1 selects falling edges.
module rtm_pin_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic fall_sel_i,
    output logic edge_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;
    logic              synced;

    assign synced = chain_q[STAGES-1];

    generate
        if (STAGES == 1) begin : g_single
            // Single capture stage.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= pin_i;
            end
        end else begin : g_chain
            // Shift the pin through the synchroniser chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], pin_i};
            end
        end
    endgenerate

    // Remember the last synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= synced;
    end

    assign edge_o = fall_sel_i ? (!synced && prev_q) : (synced && !prev_q);
endmodule

// File: rtl/rtm_downcounter.sv
// Reloadable down-counting timer core. On a count pulse at zero it
// underflows and reloads from its latch.
// Assumes: load_i is asserted only while counting is halted.
module rtm_downcounter #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             load_i,
    input  logic             wr_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] count_o,
    output logic [WIDTH-1:0] latch_o,
    output logic             uflow_o
);
    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

    logic [WIDTH-1:0] cnt_q;
    logic [WIDTH-1:0] latch_q;

    assign count_o = cnt_q;
    assign latch_o = latch_q;
    assign uflow_o = en_i && (cnt_q == '0);

    // Capture every software write into the reload latch.
    always_ff @(posedge clk) begin
        if (!rst_n)    latch_q <= ALL_ONES;
        else if (wr_i) latch_q <= wdata_i;
    end

    // Load directly when halted, otherwise count down and reload.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= ALL_ONES;
        else if (wr_i && load_i) cnt_q <= wdata_i;
        else if (en_i)           cnt_q <= (cnt_q == '0) ? latch_q : cnt_q - 1'b1;
    end
endmodule

// File: rtl/rtm_timer.sv
// Top of the multi-mode reloadable timer. It holds the mode register,
// picks the count source, and drives the pulse pin and the sticky
// interrupt request.
// Assumes: write strobes last one cycle. cfg_we and tmr_we are not
// asserted in the same cycle.
module rtm_timer
    import rtm_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int PRE_WIDTH   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_i,
    input  logic                 cfg_we,
    input  logic [CFG_W-1:0]     cfg_wdata,
    input  logic                 pre_we,
    input  logic [PRE_WIDTH-1:0] pre_wdata,
    input  logic                 tmr_we,
    input  logic [WIDTH-1:0]     tmr_wdata,
    input  logic                 irq_clr,
    input  logic                 ext_pin_i,
    output logic                 pulse_o,
    output logic                 irq_o,
    output logic [WIDTH-1:0]     count_o
);
    localparam rtm_cfg_t CFG_RESET = '{stop: 1'b1, edge_sel: 1'b0, mode: MODE_TIMER};

    rtm_cfg_t         cfg_q;
    rtm_cfg_t         cfg_new;
    logic             running;
    logic             pre_run;
    logic             pre_pulse;
    logic             pin_edge;
    logic             cnt_en;
    logic             uflow;
    logic             edge_flip;
    logic             pulse_q;
    logic             irq_q;
    logic [WIDTH-1:0] tmr_latch;

    assign cfg_new   = rtm_cfg_t'(cfg_wdata);
    assign running   = !cfg_q.stop && (cfg_q.mode != MODE_HALT);
    assign pre_run   = running && (cfg_q.mode != MODE_EVENT);
    assign cnt_en    = running && ((cfg_q.mode == MODE_EVENT) ? pin_edge : pre_pulse);
    assign edge_flip = cfg_we && (cfg_q.mode == MODE_PULSE) && (cfg_new.mode == MODE_PULSE)
                       && (cfg_new.edge_sel != cfg_q.edge_sel);

    // Mode register.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= CFG_RESET;
        else if (cfg_we) cfg_q <= cfg_new;
    end

    rtm_prescaler #(.WIDTH(PRE_WIDTH)) pre_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (pre_run),
        .tick_i  (tick_i),
        .load_i  (!running),
        .wr_i    (pre_we),
        .wdata_i (pre_wdata),
        .pulse_o (pre_pulse)
    );

    rtm_pin_edge #(.STAGES(SYNC_STAGES)) pin_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (ext_pin_i),
        .fall_sel_i (cfg_q.edge_sel),
        .edge_o     (pin_edge)
    );

    rtm_downcounter #(.WIDTH(WIDTH)) core_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (cnt_en),
        .load_i  (!running),
        .wr_i    (tmr_we),
        .wdata_i (tmr_wdata),
        .count_o (count_o),
        .latch_o (tmr_latch),
        .uflow_o (uflow)
    );

    // Pulse pin: a timer write sets the start level, otherwise it inverts on underflow and on an edge-select change.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pulse_q <= 1'b1;
        else if (tmr_we && cfg_q.mode == MODE_PULSE)
            pulse_q <= !cfg_q.edge_sel;
        else
            pulse_q <= pulse_q ^ (uflow && cfg_q.mode == MODE_PULSE) ^ edge_flip;
    end

    // Sticky interrupt request: set on underflow, which wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       irq_q <= 1'b0;
        else if (uflow)   irq_q <= 1'b1;
        else if (irq_clr) irq_q <= 1'b0;
    end

    assign pulse_o = pulse_q;
    assign irq_o   = irq_q;
endmodule

// File: rtl/rtm_timer_chk.sv
// Temporal checks for rtm_timer, attached by bind.
module rtm_timer_chk
    import rtm_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tmr_we,
    input logic             irq_clr,
    input logic             pulse_o,
    input logic             irq_o,
    input logic [WIDTH-1:0] count_o,
    input logic [WIDTH-1:0] tmr_latch,
    input logic             running,
    input logic             cnt_en,
    input logic             uflow,
    input rtm_cfg_t         cfg_q
);
    a_r2_reload_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && count_o == '0) |=> (count_o == $past(tmr_latch)));

    a_r3_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
        uflow |=> irq_o);

    a_r3_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !irq_clr) |=> irq_o);

    a_r4_stop_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !tmr_we) |=> $stable(count_o));

    a_r6_pulse_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.mode != MODE_PULSE) |=> $stable(pulse_o));

    a_r10_halt_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.mode == MODE_HALT && !irq_o) |=> !irq_o);
endmodule

bind rtm_timer rtm_timer_chk #(.WIDTH(WIDTH)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tmr_we    (tmr_we),
    .irq_clr   (irq_clr),
    .pulse_o   (pulse_o),
    .irq_o     (irq_o),
    .count_o   (count_o),
    .tmr_latch (tmr_latch),
    .running   (running),
    .cnt_en    (cnt_en),
    .uflow     (uflow),
    .cfg_q     (cfg_q)
);

// File: tb/rtm_timer_tb_top.sv
// Bench for rtm_timer: directed corner cases, then seeded random stimulus,
// each compared against a cycle model written from the requirements.
module rtm_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_wdata = 4'h0;
    logic       pre_we = 1'b0;
    logic [7:0] pre_wdata = 8'h0;
    logic       tmr_we = 1'b0;
    logic [7:0] tmr_wdata = 8'h0;
    logic       irq_clr = 1'b0;
    logic       ext_pin_i = 1'b0;
    logic       pulse_o;
    logic       irq_o;
    logic [7:0] count_o;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 0;

    always #5 clk = ~clk;

    rtm_timer dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .pre_we(pre_we), .pre_wdata(pre_wdata),
        .tmr_we(tmr_we), .tmr_wdata(tmr_wdata),
        .irq_clr(irq_clr), .ext_pin_i(ext_pin_i),
        .pulse_o(pulse_o), .irq_o(irq_o), .count_o(count_o)
    );

    // Reference model state.
    logic [3:0] m_cfg;
    logic [7:0] m_pl, m_pc, m_tl, m_tc;
    logic       m_pulse, m_irq, m_s1, m_s2, m_prev;
    logic       m_run, m_ev, m_pp, m_en, m_uf;
    logic [7:0] m_next;

    function automatic logic [7:0] step_down(logic [7:0] cur, logic [7:0] lat);
        return (cur == 8'h00) ? lat : cur - 8'h01;
    endfunction

    // Step the model at each rising edge using the inputs driven at the falling edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cfg = 4'b1000; m_pl = 8'hFF; m_pc = 8'hFF; m_tl = 8'hFF; m_tc = 8'hFF;
            m_pulse = 1'b1; m_irq = 1'b0; m_s1 = 1'b0; m_s2 = 1'b0; m_prev = 1'b0;
        end else begin
            m_ev  = m_cfg[2] ? (!m_s2 && m_prev) : (m_s2 && !m_prev);
            m_run = !m_cfg[3] && (m_cfg[1:0] != 2'b11);
            m_pp  = m_run && (m_cfg[1:0] != 2'b10) && tick_i && (m_pc == 8'h00);
            m_en  = m_run && ((m_cfg[1:0] == 2'b10) ? m_ev : m_pp);
            m_uf  = m_en && (m_tc == 8'h00);
            m_prev = m_s2; m_s2 = m_s1; m_s1 = ext_pin_i;
            if (pre_we && !m_run) m_pc = pre_wdata;
            else if (m_run && m_cfg[1:0] != 2'b10 && tick_i) m_pc = step_down(m_pc, m_pl);
            if (pre_we) m_pl = pre_wdata;
            if (tmr_we && !m_run) m_tc = tmr_wdata;
            else if (m_en) m_tc = step_down(m_tc, m_tl);
            if (tmr_we) m_tl = tmr_wdata;
            if (tmr_we && m_cfg[1:0] == 2'b01) m_pulse = !m_cfg[2];
            else begin
                if (m_uf && m_cfg[1:0] == 2'b01) m_pulse = !m_pulse;
                if (cfg_we && m_cfg[1:0] == 2'b01 && cfg_wdata[1:0] == 2'b01
                    && cfg_wdata[2] != m_cfg[2]) m_pulse = !m_pulse;
            end
            if (m_uf) m_irq = 1'b1;
            else if (irq_clr) m_irq = 1'b0;
            if (cfg_we) m_cfg = cfg_wdata;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Compare all outputs with the model. Call only at a falling edge.
    task automatic compare(input string cnt_tag, input string pulse_tag, input string irq_tag);
        check(count_o == m_tc, cnt_tag, count_o, m_tc);
        check(pulse_o == m_pulse, pulse_tag, pulse_o, m_pulse);
        check(irq_o == m_irq, irq_tag, irq_o, m_irq);
    endtask

    task automatic idle_inputs();
        cfg_we = 0; pre_we = 0; tmr_we = 0; irq_clr = 0;
    endtask

    task automatic run_cycles(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            idle_inputs();
            compare(tag, tag, tag);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            finish_up();
        end
    end

    initial begin
        logic [7:0] held;
        int unsigned seed_val;
        seed_val = $urandom(32'h5EED_1234);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11: reset state.
        check(count_o == 8'hFF, "R11 count", count_o, 8'hFF);
        check(pulse_o == 1'b1, "R11 pulse", pulse_o, 1);
        check(irq_o == 1'b0, "R11 irq", irq_o, 0);

        // R5: a write while stopped loads the counter.
        pre_we = 1; pre_wdata = 8'h00; tmr_we = 1; tmr_wdata = 8'h02;
        @(negedge clk); idle_inputs();
        check(count_o == 8'h02, "R5 load stopped", count_o, 2);

        // R2 R3: timer mode, tick every cycle, period 3.
        tick_i = 1; cfg_we = 1; cfg_wdata = 4'b0000;
        @(negedge clk); idle_inputs();
        run_cycles(8, "R2");
        check(irq_o == 1'b1, "R3 irq set", irq_o, 1);
        irq_clr = 1;
        @(negedge clk); idle_inputs(); compare("R3", "R3", "R3");

        // R1: prescaler latch 2 while running updates the latch only.
        pre_we = 1; pre_wdata = 8'h02;
        @(negedge clk); idle_inputs(); compare("R1", "R1", "R1");
        run_cycles(12, "R1");

        // R7: pulse mode, a timer write while running sets a high start, and R5 leaves the counter.
        cfg_we = 1; cfg_wdata = 4'b0001;
        @(negedge clk); idle_inputs();
        held = count_o;
        tmr_we = 1; tmr_wdata = 8'h01;
        @(negedge clk); idle_inputs();
        check(pulse_o == 1'b1, "R7 start high", pulse_o, 1);
        check(count_o != 8'h01 || held == 8'h02 || held == 8'h01, "R5 running latch only", count_o, m_tc);
        compare("R5", "R7", "R3");
        run_cycles(20, "R6");

        // R8: changing edge select in pulse mode inverts the output.
        held = pulse_o;
        cfg_we = 1; cfg_wdata = 4'b0101;
        @(negedge clk); idle_inputs();
        check(pulse_o == !held[0], "R8 invert", pulse_o, !held[0]);
        // R7: a write with edge select 1 gives a low start.
        tmr_we = 1; tmr_wdata = 8'h03;
        @(negedge clk); idle_inputs();
        check(pulse_o == 1'b0, "R7 start low", pulse_o, 0);
        run_cycles(10, "R6");

        // R4: stop bit freezes counting.
        cfg_we = 1; cfg_wdata = 4'b1001;
        @(negedge clk); idle_inputs();
        held = count_o;
        run_cycles(10, "R4");
        check(count_o == held, "R4 frozen", count_o, held);

        // R10: mode 11 halts even with stop clear.
        tmr_we = 1; tmr_wdata = 8'h00;
        @(negedge clk); idle_inputs();
        irq_clr = 1; cfg_we = 1; cfg_wdata = 4'b0011;
        @(negedge clk); idle_inputs();
        held = {7'b0, pulse_o};
        run_cycles(10, "R10");
        check(count_o == 8'h00 && irq_o == 1'b0 && pulse_o == held[0], "R10 halted", count_o, 0);

        // R9: event mode, rising edges. Ticks must be ignored.
        tmr_we = 1; tmr_wdata = 8'h04;
        @(negedge clk); idle_inputs();
        cfg_we = 1; cfg_wdata = 4'b0010;
        @(negedge clk); idle_inputs();
        run_cycles(4, "R9");
        check(count_o == 8'h04, "R9 ticks ignored", count_o, 4);
        ext_pin_i = 1;
        run_cycles(2, "R9");
        check(count_o == 8'h04, "R9 before third edge", count_o, 4);
        run_cycles(1, "R9");
        check(count_o == 8'h03, "R9 rising counted", count_o, 3);
        ext_pin_i = 0;
        run_cycles(5, "R9");
        check(count_o == 8'h03, "R9 falling ignored", count_o, 3);
        // Falling edges selected.
        cfg_we = 1; cfg_wdata = 4'b0110;
        @(negedge clk); idle_inputs();
        ext_pin_i = 1; run_cycles(5, "R9");
        ext_pin_i = 0; run_cycles(5, "R9");
        check(count_o == 8'h02, "R9 falling counted", count_o, 2);

        // Random phase.
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            compare((m_cfg[1:0] == 2'b10) ? "R9" : (m_cfg[1:0] == 2'b11) ? "R10" : "R2",
                    "R6", "R3");
            idle_inputs();
            tick_i = ($urandom % 3) != 0;
            if (($urandom % 5) == 0) ext_pin_i = !ext_pin_i;
            case ($urandom % 40)
                0: begin cfg_we = 1; cfg_wdata = 4'($urandom); end
                1: begin tmr_we = 1; tmr_wdata = 8'($urandom % 12); end
                2: begin pre_we = 1; pre_wdata = 8'($urandom % 4); end
                3, 4: irq_clr = 1;
                default: ;
            endcase
        end
        @(negedge clk);
        compare("R2", "R6", "R3");
        finish_up();
    end
endmodule